// File: doc/BRIEF.md
# Addressed-Station Serial Receiver

This block receives asynchronous serial frames from a line that several stations share with a single sender. Each frame holds a start bit (0), a data field sent least significant bit first, one extra station-select bit, and one or two stop bits (1). The line rests at 1 between frames. The station-select bit marks each frame as an address frame (bit = 1) or a payload frame (bit = 0). The receiver compares every address frame with its programmed `station_id`. It delivers payload frames only while the most recent address frame matched. A mismatch closes the gate, and it stays closed until a matching address frame arrives.

The line is sampled at sixteen ticks per bit. The tick comes from a divider, one tick every `baud_div + 1` clocks. A start bit is accepted only if the line is still low at the middle of the bit. Every bit value is the majority of the samples at ticks 7, 8 and 9 of that bit. The byte of each accepted frame is written to `rdata`, and `rx_full` is set. Software reads `rdata` and then pulses `clr_full`. A stop bit that samples low sets `frame_err`. A good frame that arrives while `rx_full` is still set raises `overrun`. Both errors drive `err_irq`, and `clr_err` clears them.

The frame engine has six states. IDLE moves to START on a low sample. START returns to IDLE on a false start, or moves to DATA after sixteen ticks. DATA moves to SEL after the last data bit. SEL moves to STOP1. STOP1 judges the stop bit at mid-bit, then goes to IDLE (one stop bit) or to STOP2 (two stop bits). STOP2 goes to IDLE at the middle of the second stop bit. The station gate has two states. HUNT moves to OPEN on a matching address frame. OPEN moves to HUNT on a mismatching address frame. Payload frames leave the gate as it is.

Top module: `mpr_uart_rx`

## Requirements
- R1: Data bits arrive least significant bit first. With `fmt_seven`=1 the field is 7 bits and `rdata[7]` reads 0. With `fmt_seven`=0 the field is 8 bits. The station-select bit follows the last data bit.
- R2: After reset, with `mp_filter_en`=1, a payload frame (select bit 0) does not change `rdata`, `rx_full`, `rx_irq` or `err_irq`.
- R3: An address frame (select bit 1) whose data equals `station_id` is delivered to `rdata` and opens the gate. The payload frames that follow it are delivered. In 7-bit mode only bits 6:0 are compared.
- R4: An address frame that does not match is not delivered and closes the gate. Payload frames after it are dropped until a matching address frame arrives.
- R5: With `mp_filter_en`=0, every frame with a good stop bit is delivered, whatever its select bit.
- R6: A delivered frame sets `rx_full` and `rx_irq`. A one-cycle `clr_full` pulse clears both.
- R7: A frame that would be delivered but whose first stop bit samples 0 sets `frame_err` and `err_irq`, and leaves `rdata` and `rx_full` unchanged.
- R8: A frame that would be delivered while `rx_full`=1 sets `overrun` and `err_irq`, and `rdata` keeps the older byte.
- R9: A disturbance one tick wide near the centre of a bit does not change the value received for that bit.
- R10: A low pulse on an idle line shorter than half a bit yields no frame, and the receiver is ready for the next real start bit.
- R11: A one-cycle `clr_err` pulse clears `frame_err`, `overrun` and `err_irq`.
- R12: With `fmt_two_stop`=1, only the first stop bit is checked. A 0 in the second stop bit raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idles at 1 |
| baud_div | input | 8 | One sample tick every baud_div+1 clocks |
| fmt_seven | input | 1 | 1: 7 data bits, 0: 8 data bits |
| fmt_two_stop | input | 1 | 1: two stop bits per frame |
| mp_filter_en | input | 1 | 1: station gating active |
| station_id | input | 8 | This station's address |
| clr_full | input | 1 | Pulse: clear rx_full after reading rdata |
| clr_err | input | 1 | Pulse: clear frame_err and overrun |
| rdata | output | 8 | Last delivered byte |
| rx_full | output | 1 | rdata holds an unread byte |
| frame_err | output | 1 | Stop bit was sampled low |
| overrun | output | 1 | Byte lost while rx_full was set |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
If the gate holds the wrong state, the fault shows at the very next payload frame. Either a frame that should be dropped appears in `rdata` together with `rx_full`, or a frame that should be delivered never appears. The bench therefore follows every address frame with payload frames before it checks. A sampling phase that is off by a few ticks, or a wrong bit counter, shows up within one frame as a wrong byte or a false framing error. A fault that affects only 7-bit or two-stop formats stays hidden until the bench sends a frame in that format.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_SEL, S_STOP1, S_STOP2
    } rx_state_t;

    typedef enum logic {
        G_HUNT, G_OPEN
    } gate_state_t;
endpackage

// File: rtl/mpr_baud_tick.sv
module mpr_baud_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/mpr_frame_fsm.sv
module mpr_frame_fsm
    import mpr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic          seven,
    input  logic          two_stop,
    output logic          done,
    output logic [DW-1:0] dbyte,
    output logic          sel_bit,
    output logic          stop_ok
);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] LAST_FULL  = BW'(DW - 1);
    localparam logic [BW-1:0] LAST_SHORT = BW'(DW - 2);

    rx_state_t      state_q, state_d;
    logic [3:0]     cnt_q;
    logic [1:0]     ones_q;
    logic [BW-1:0]  bitn_q;
    logic [DW-1:0]  shreg_q;
    logic           wrap_q;
    logic           mid, last, samp, maj_now;
    logic [BW-1:0]  last_bit;

    assign mid      = (cnt_q == 4'd9);
    assign last     = (cnt_q == 4'd15);
    assign samp     = (cnt_q >= 4'd7) && (cnt_q <= 4'd9);
    assign maj_now  = (({1'b0, ones_q} + {2'b00, rx}) >= 3'd2);
    assign last_bit = seven ? LAST_SHORT : LAST_FULL;
    assign dbyte    = seven ? {1'b0, shreg_q[DW-1:1]} : shreg_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                S_IDLE:  if (!rx) state_d = S_START;
                S_START: begin
                    if (mid && maj_now) state_d = S_IDLE;
                    else if (last)      state_d = S_DATA;
                end
                S_DATA:  if (last && bitn_q == last_bit) state_d = S_SEL;
                S_SEL:   if (last) state_d = S_STOP1;
                S_STOP1: if (mid) state_d = two_stop ? S_STOP2 : S_IDLE;
                S_STOP2: if (mid && wrap_q) state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // sampling datapath and frame results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ones_q  <= '0;
            bitn_q  <= '0;
            shreg_q <= '0;
            wrap_q  <= 1'b0;
            done    <= 1'b0;
            sel_bit <= 1'b0;
            stop_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state_q == S_IDLE) begin
                    cnt_q  <= rx ? 4'd0 : 4'd1;
                    ones_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 4'd1;
                    if (last)      ones_q <= '0;
                    else if (samp) ones_q <= ones_q + {1'b0, rx};
                end
                unique case (state_q)
                    S_START: if (last) bitn_q <= '0;
                    S_DATA: begin
                        if (mid)  shreg_q <= {maj_now, shreg_q[DW-1:1]};
                        if (last) bitn_q  <= bitn_q + 1'b1;
                    end
                    S_SEL:   if (mid) sel_bit <= maj_now;
                    S_STOP1: if (mid) begin
                        done    <= 1'b1;
                        stop_ok <= maj_now;
                        wrap_q  <= 1'b0;
                    end
                    S_STOP2: if (last) wrap_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpr_rx_regs.sv
module mpr_rx_regs
    import mpr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] dbyte,
    input  logic          sel_bit,
    input  logic          stop_ok,
    input  logic          filter_en,
    input  logic          seven,
    input  logic [DW-1:0] station_id,
    input  logic          clr_full,
    input  logic          clr_err,
    output logic [DW-1:0] rdata,
    output logic          rx_full,
    output logic          frame_err,
    output logic          overrun,
    output logic          gate_open
);
    gate_state_t gate_q, gate_d;
    logic        id_hit, eligible;

    assign id_hit   = seven ? (dbyte[DW-2:0] == station_id[DW-2:0])
                            : (dbyte == station_id);
    assign eligible = !filter_en || (sel_bit ? id_hit : (gate_q == G_OPEN));
    assign gate_open = (gate_q == G_OPEN);

    always_comb begin
        gate_d = gate_q;
        if (done && stop_ok && sel_bit) begin
            unique case (gate_q)
                G_HUNT:  if (id_hit)  gate_d = G_OPEN;
                G_OPEN:  if (!id_hit) gate_d = G_HUNT;
                default: gate_d = G_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= G_HUNT;
        else        gate_q <= gate_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata     <= '0;
            rx_full   <= 1'b0;
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (clr_full) rx_full <= 1'b0;
            if (clr_err) begin
                frame_err <= 1'b0;
                overrun   <= 1'b0;
            end
            if (done && eligible) begin
                if (!stop_ok)     frame_err <= 1'b1;
                else if (rx_full) overrun   <= 1'b1;
                else begin
                    rdata   <= dbyte;
                    rx_full <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mpr_uart_rx.sv
module mpr_uart_rx #(
    parameter int DIV_W = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             fmt_seven,
    input  logic             fmt_two_stop,
    input  logic             mp_filter_en,
    input  logic [DW-1:0]    station_id,
    input  logic             clr_full,
    input  logic             clr_err,
    output logic [DW-1:0]    rdata,
    output logic             rx_full,
    output logic             frame_err,
    output logic             overrun,
    output logic             rx_irq,
    output logic             err_irq
);
    logic [1:0]    sync_q;
    logic          tick, frm_done, frm_sel, frm_stop_ok, gate_open;
    logic [DW-1:0] frm_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    mpr_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    mpr_frame_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(sync_q[1]),
        .seven(fmt_seven), .two_stop(fmt_two_stop),
        .done(frm_done), .dbyte(frm_byte), .sel_bit(frm_sel),
        .stop_ok(frm_stop_ok)
    );

    mpr_rx_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .done(frm_done), .dbyte(frm_byte),
        .sel_bit(frm_sel), .stop_ok(frm_stop_ok), .filter_en(mp_filter_en),
        .seven(fmt_seven), .station_id(station_id), .clr_full(clr_full),
        .clr_err(clr_err), .rdata(rdata), .rx_full(rx_full),
        .frame_err(frame_err), .overrun(overrun), .gate_open(gate_open)
    );

    assign rx_irq  = rx_full;
    assign err_irq = frame_err | overrun;
endmodule

// File: rtl/mpr_uart_rx_chk.sv
module mpr_uart_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frm_done,
    input logic          frm_sel,
    input logic          gate_open,
    input logic          mp_filter_en,
    input logic          clr_full,
    input logic          clr_err,
    input logic [DW-1:0] rdata,
    input logic          rx_full,
    input logic          frame_err,
    input logic          overrun
);
    // R6
    full_set_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(frm_done));
    // R6
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_full && !frm_done) |=> !rx_full);
    // R7
    ferr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> ($stable(rdata) && !$rose(rx_full)));
    // R8
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(rdata));
    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !frm_done) |=> (!frame_err && !overrun));
    // R4
    hunt_blocks_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && mp_filter_en && !frm_sel && !gate_open) |=>
            ($stable(rdata) && !$rose(rx_full)));
endmodule

bind mpr_uart_rx mpr_uart_rx_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_sel(frm_sel),
    .gate_open(gate_open), .mp_filter_en(mp_filter_en), .clr_full(clr_full),
    .clr_err(clr_err), .rdata(rdata), .rx_full(rx_full),
    .frame_err(frame_err), .overrun(overrun)
);

// File: tb/sim_mpr_uart_rx.sv
module sim_mpr_uart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] baud_div = 8'd1;
    logic       fmt_seven = 1'b0, fmt_two_stop = 1'b0, mp_filter_en = 1'b1;
    logic [7:0] station_id = 8'h5A;
    logic       clr_full = 1'b0, clr_err = 1'b0;
    logic [7:0] rdata;
    logic       rx_full, frame_err, overrun, rx_irq, err_irq;

    int checks = 0, failures = 0;

    // reference model of the programmer-visible state
    logic       m_open = 1'b0, m_full = 1'b0, m_fe = 1'b0, m_ov = 1'b0;
    logic [7:0] m_rdata = 8'h00;

    always #10 clk = ~clk;

    mpr_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_div(baud_div),
        .fmt_seven(fmt_seven), .fmt_two_stop(fmt_two_stop),
        .mp_filter_en(mp_filter_en), .station_id(station_id),
        .clr_full(clr_full), .clr_err(clr_err), .rdata(rdata),
        .rx_full(rx_full), .frame_err(frame_err), .overrun(overrun),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        chk(tag, "rx_full", 32'(rx_full), 32'(m_full));
        chk(tag, "rdata", 32'(rdata), 32'(m_rdata));
        chk(tag, "frame_err", 32'(frame_err), 32'(m_fe));
        chk(tag, "overrun", 32'(overrun), 32'(m_ov));
        chk(tag, "rx_irq", 32'(rx_irq), 32'(m_full));
        chk(tag, "err_irq", 32'(err_irq), 32'(m_fe | m_ov));
    endtask

    function automatic logic model_hit(input logic [7:0] b);
        return fmt_seven ? (b[6:0] == station_id[6:0]) : (b == station_id);
    endfunction

    task automatic model_frame(input logic [7:0] b, input logic sel, input logic s1);
        logic [7:0] d;
        logic hit, elig;
        d    = fmt_seven ? {1'b0, b[6:0]} : b;
        hit  = model_hit(d);
        elig = !mp_filter_en || (sel ? hit : m_open);
        if (!s1) begin
            if (elig) m_fe = 1'b1;
        end else begin
            if (sel) m_open = hit;
            if (elig) begin
                if (m_full) m_ov = 1'b1;
                else begin
                    m_rdata = d;
                    m_full  = 1'b1;
                end
            end
        end
    endtask

    task automatic drive_bit(input logic v, input logic glitch);
        int bc = 16 * (int'(baud_div) + 1);
        int g0 = bc / 2 - 1;
        for (int k = 0; k < bc; k++) begin
            @(negedge clk);
            rxd = (glitch && k >= g0 && k < g0 + int'(baud_div) + 1) ? ~v : v;
        end
    endtask

    task automatic send(input logic [7:0] b, input logic sel, input logic s1,
                        input logic s2, input int glitch_bit);
        int nd = fmt_seven ? 7 : 8;
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < nd; i++) drive_bit(b[i], glitch_bit == i);
        drive_bit(sel, 1'b0);
        drive_bit(s1, 1'b0);
        if (fmt_two_stop) drive_bit(s2, 1'b0);
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
        model_frame(b, sel, s1);
    endtask

    task automatic pulse_full();
        @(negedge clk); clr_full = 1'b1;
        @(negedge clk); clr_full = 1'b0;
        m_full = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        m_fe = 1'b0;
        m_ov = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        check_all("R6 reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        send(8'h11, 1'b0, 1'b1, 1'b1, -1); check_all("R2 payload before any address");
        send(8'h33, 1'b1, 1'b1, 1'b1, -1); check_all("R4 mismatched address");
        send(8'h22, 1'b0, 1'b1, 1'b1, -1); check_all("R4 payload after mismatch");
        send(8'h5A, 1'b1, 1'b1, 1'b1, -1); check_all("R3 matching address delivered");
        pulse_full();                       check_all("R6 clear full");
        send(8'hC3, 1'b0, 1'b1, 1'b1, -1); check_all("R1 R3 payload delivered");
        send(8'h44, 1'b0, 1'b1, 1'b1, -1); check_all("R8 overrun keeps old byte");
        pulse_err();                        check_all("R11 clear errors");
        pulse_full();
        send(8'h81, 1'b0, 1'b0, 1'b1, -1); check_all("R7 framing error");
        pulse_err();                        check_all("R11 clear framing error");
        send(8'hA5, 1'b0, 1'b1, 1'b1, 3);  check_all("R9 glitch at bit centre");
        pulse_full();

        // R10: short low pulse then a real frame
        @(negedge clk); rxd = 1'b0;
        repeat (int'(baud_div) + 1) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        check_all("R10 false start ignored");
        send(8'h0F, 1'b0, 1'b1, 1'b1, -1); check_all("R10 frame after false start");
        pulse_full();

        fmt_seven = 1'b1; fmt_two_stop = 1'b1;
        send(8'hDA, 1'b1, 1'b1, 1'b1, -1); check_all("R1 R3 seven-bit address");
        pulse_full();
        send(8'h3C, 1'b0, 1'b0, 1'b1, -1); check_all("R7 seven-bit framing error");
        pulse_err();
        send(8'h6E, 1'b0, 1'b1, 1'b0, -1); check_all("R12 second stop not checked");
        pulse_full();
        fmt_seven = 1'b0; fmt_two_stop = 1'b0;

        mp_filter_en = 1'b0;
        send(8'h33, 1'b1, 1'b1, 1'b1, -1); check_all("R5 unfiltered address");
        pulse_full();
        send(8'h77, 1'b0, 1'b1, 1'b1, -1); check_all("R5 unfiltered payload");
        pulse_full();
        mp_filter_en = 1'b1;
        send(8'h99, 1'b0, 1'b1, 1'b1, -1); check_all("R4 gate closed by earlier mismatch");

        baud_div = 8'd3;
        send(8'h5A, 1'b1, 1'b1, 1'b1, -1); check_all("R3 slower rate address");
        pulse_full();
        baud_div = 8'd1;

        for (int n = 0; n < 70; n++) begin
            logic [7:0] b;
            logic sel, s1;
            if ($urandom % 2 == 0) pulse_full();
            if ($urandom % 4 == 0) pulse_err();
            if ($urandom % 10 == 0) mp_filter_en = ~mp_filter_en;
            fmt_seven    = ($urandom % 4 == 0);
            fmt_two_stop = ($urandom % 4 == 0);
            sel = ($urandom % 3 == 0);
            b   = 8'($urandom);
            if (sel && ($urandom % 2 == 0)) b = station_id;
            s1  = ($urandom % 10 != 0);
            send(b, sel, s1, 1'b1, -1);
            check_all("R1 R3 R4 R5 R8 random");
        end
        finish_run();
    end
endmodule